// File: doc/BRIEF.md
# Thermal Monitor Register Bank with Set/Clear/Toggle Aliases

This block is the memory-mapped register file of an on-chip temperature monitor. It holds ten 32-bit registers: control, status, the measured temperature, thresholds, measurement control, measurement period, clock divider, power-up delay and two calibration words. The host reaches it through a plain word-addressed port. The two low address bits of each access select how a write is applied, so software can change single bits in one bus write without a read-modify-write sequence. Alias 0 replaces the whole register. Alias 1 ORs the data in. Alias 2 clears the bits written as one. Alias 3 inverts the bits written as one.

Two registers take values from hardware. The status register collects event flags that stay set until software clears them by writing ones through the clear alias. A hardware event in the same cycle as that clear wins, so no event is lost. The temperature register is loaded only by the sensor side and cannot be written by the host. Reads are combinational and return the register's current value at any of its four alias addresses.

Top module: `tsr_bank`

## Requirements
- R1: A write with address bits [1:0] = 0 to a read/write register replaces its full value, visible on a read in the next cycle.
- R2: A write with address bits [1:0] = 1 ORs the write data into the register and leaves the other bits unchanged.
- R3: A write with address bits [1:0] = 2 clears the bits that are one in the write data and leaves the other bits unchanged.
- R4: A write with address bits [1:0] = 3 inverts the bits that are one in the write data.
- R5: A read returns, in the same cycle, the current value of the register, whichever of its four alias addresses (address bits [1:0] = 0..3) is presented.
- R6: The temperature register is read-only to the host: writes through any alias are ignored, and it loads `dataIn` on a cycle where `dataLoad` is high.
- R7: Status bits are sticky: a one on `hwSet` sets the bit, and it stays set until a write through the clear alias with a one in that bit. Writes to status through aliases 0, 1 and 3 have no effect.
- R8: When `hwSet` and a clear-alias write hit the same status bit in the same cycle, the bit ends up set.
- R9: After reset every register reads zero.
- R10: A write to an address block that holds no register changes no register, and a read from it returns zero.
- R11: The register base byte offsets are: control 0x000, status 0x010, temperature 0x020, threshold 0x030, measurement control 0x200, period 0x270, divider 0x280, power-up delay 0x2B0, calibration A 0x2E0 and calibration B 0x2F0. The word address is the byte address divided by four, plus the alias number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe for the current address |
| addr | input | ADDR_W (8) | Word address; bits [1:0] select the alias |
| wrData | input | DATA_W (32) | Host write data |
| rdData | output | DATA_W (32) | Combinational read data for `addr` |
| hwSet | input | DATA_W (32) | Hardware event flags ORed into the status register |
| dataIn | input | DATA_W (32) | New temperature sample |
| dataLoad | input | 1 | Loads `dataIn` into the temperature register |

## Verification
A wrong alias decode appears as a wrong value on the first read after the write, one cycle later. Because a read at a different alias of the same register returns the same value, the error cannot hide behind the address used to check it. A sticky bit lost to the clear priority, or a temperature register touched by a host write, shows up on the next read of that register. Clock-by-clock properties catch the same faults at the register outputs on the cycle after the offending write.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int NREG = 10;

  // Register indices
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_TEMP  = 2;
  localparam int IDX_THR   = 3;
  localparam int IDX_MEAS  = 4;
  localparam int IDX_PER   = 5;
  localparam int IDX_DIV   = 6;
  localparam int IDX_PUD   = 7;
  localparam int IDX_CALA  = 8;
  localparam int IDX_CALB  = 9;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } aliasOp_t;

  typedef enum logic [1:0] {
    KIND_RW,
    KIND_STICKY,
    KIND_HWDATA
  } regKind_t;

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic [NREG-1:0] rdSel;
    aliasOp_t        op;
  } tsrStrobe_t;

  // Block number (byte offset / 16) of each register
  function automatic int blockOf(input int idx);
    case (idx)
      IDX_CTRL: return 'h00;
      IDX_STAT: return 'h01;
      IDX_TEMP: return 'h02;
      IDX_THR:  return 'h03;
      IDX_MEAS: return 'h20;
      IDX_PER:  return 'h27;
      IDX_DIV:  return 'h28;
      IDX_PUD:  return 'h2B;
      IDX_CALA: return 'h2E;
      default:  return 'h2F;
    endcase
  endfunction

  function automatic regKind_t kindOf(input int idx);
    if (idx == IDX_STAT) return KIND_STICKY;
    if (idx == IDX_TEMP) return KIND_HWDATA;
    return KIND_RW;
  endfunction

endpackage

// File: rtl/tsr_decode.sv
module tsr_decode
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output tsrStrobe_t        strobe
);

  localparam int BLK_W = ADDR_W - 2;

  logic [BLK_W-1:0] blk;
  assign blk = addr[ADDR_W-1:2];

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic hit;
    assign hit = (blk == BLK_W'(blockOf(i)));
    assign strobe.rdSel[i] = hit;
    assign strobe.wrSel[i] = hit & wrEn;
  end

  assign strobe.op = aliasOp_t'(addr[1:0]);

endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tsrStrobe_t                   strobe,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [DATA_W-1:0]            hwSet,
  input  logic [DATA_W-1:0]            dataIn,
  input  logic                         dataLoad,
  output logic [NREG-1:0][DATA_W-1:0]  regFile,
  output logic [DATA_W-1:0]            rdData
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;

    if (kindOf(i) == KIND_RW) begin : g_rw
      always_comb begin
        nxt = q;
        if (strobe.wrSel[i]) begin
          unique case (strobe.op)
            OP_WRITE: nxt = wrData;
            OP_SET:   nxt = q | wrData;
            OP_CLEAR: nxt = q & ~wrData;
            OP_FLIP:  nxt = q ^ wrData;
          endcase
        end
      end
    end else if (kindOf(i) == KIND_STICKY) begin : g_sticky
      always_comb begin
        nxt = q;
        if (strobe.wrSel[i] && strobe.op == OP_CLEAR) nxt = nxt & ~wrData;
        nxt = nxt | hwSet;  // hardware event wins over a same-cycle clear
      end
    end else begin : g_hw
      assign nxt = dataLoad ? dataIn : q;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= nxt;
    end

    assign regFile[i] = q;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NREG; i++) begin
      if (strobe.rdSel[i]) rdData = rdData | regFile[i];
    end
  end

endmodule

// File: rtl/tsr_bank.sv
module tsr_bank
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] hwSet,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataLoad
);

  tsrStrobe_t                  strobe;
  logic [NREG-1:0][DATA_W-1:0] regFile;

  tsr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  tsr_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .hwSet    (hwSet),
    .dataIn   (dataIn),
    .dataLoad (dataLoad),
    .regFile  (regFile),
    .rdData   (rdData)
  );

endmodule

// File: rtl/tsr_bank_checker.sv
module tsr_bank_checker
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wrData,
  input logic [DATA_W-1:0]           hwSet,
  input logic                        dataLoad,
  input logic [NREG-1:0][DATA_W-1:0] regFile
);

  logic ctrlHit;
  assign ctrlHit = wrEn && (addr[ADDR_W-1:2] == '0);

  // R1
  p_plain_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && addr[1:0] == 2'd0) |=> regFile[IDX_CTRL] == $past(wrData));

  // R2
  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && addr[1:0] == 2'd1) |=>
      regFile[IDX_CTRL] == ($past(regFile[IDX_CTRL]) | $past(wrData)));

  // R3
  p_clear_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && addr[1:0] == 2'd2) |=>
      regFile[IDX_CTRL] == ($past(regFile[IDX_CTRL]) & ~$past(wrData)));

  // R4
  p_flip_alias_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && addr[1:0] == 2'd3) |=>
      regFile[IDX_CTRL] == ($past(regFile[IDX_CTRL]) ^ $past(wrData)));

  // R6
  p_temp_readonly_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dataLoad |=> regFile[IDX_TEMP] == $past(regFile[IDX_TEMP]));

  // R8
  p_hw_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|hwSet) |=> (regFile[IDX_STAT] & $past(hwSet)) == $past(hwSet));

endmodule

bind tsr_bank tsr_bank_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .hwSet    (hwSet),
  .dataLoad (dataLoad),
  .regFile  (regFile)
);

// File: tb/tsr_bank_bench.sv
module tsr_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam int A_CTRL = 'h000;
  localparam int A_STAT = 'h010;
  localparam int A_TEMP = 'h020;
  localparam int A_THR  = 'h030;
  localparam int A_MEAS = 'h200;
  localparam int A_PER  = 'h270;
  localparam int A_DIV  = 'h280;
  localparam int A_PUD  = 'h2B0;
  localparam int A_CALA = 'h2E0;
  localparam int A_CALB = 'h2F0;
  localparam int A_HOLE = 'h040;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] hwSet = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              dataLoad = 1'b0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tsr_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hwSet(hwSet), .dataIn(dataIn), .dataLoad(dataLoad)
  );

  function automatic logic [ADDR_W-1:0] wordAddr(input int byteOff, input int al);
    return ADDR_W'((byteOff >> 2) + al);
  endfunction

  // One write cycle, inputs changed at the falling edge
  task automatic regWrite(input int byteOff, input int al, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = wordAddr(byteOff, al);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regCheck(input int byteOff, input int al, input logic [DATA_W-1:0] exp,
                          input string req);
    addr = wordAddr(byteOff, al);
    #1;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: addr 0x%03h alias %0d got 0x%08h expected 0x%08h",
               req, byteOff, al, rdData, exp);
    end
  endtask

  task automatic testReset();
    int offs[10] = '{A_CTRL, A_STAT, A_TEMP, A_THR, A_MEAS, A_PER, A_DIV, A_PUD, A_CALA, A_CALB};
    @(negedge clk);
    foreach (offs[i]) regCheck(offs[i], 0, 32'h0, "R9");
  endtask

  task automatic testAliases();
    regWrite(A_CTRL, 0, 32'hA5A5_0F0F);
    regCheck(A_CTRL, 0, 32'hA5A5_0F0F, "R1");
    for (int al = 1; al < 4; al++) regCheck(A_CTRL, al, 32'hA5A5_0F0F, "R5");
    regWrite(A_CTRL, 1, 32'h0000_F000);
    regCheck(A_CTRL, 0, 32'hA5A5_FF0F, "R2");
    regWrite(A_CTRL, 2, 32'hA500_0000);
    regCheck(A_CTRL, 0, 32'h00A5_FF0F, "R3");
    regWrite(A_CTRL, 3, 32'hFFFF_0000);
    regCheck(A_CTRL, 0, 32'hFF5A_FF0F, "R4");
    regWrite(A_CTRL, 3, 32'hFFFF_0000);
    regCheck(A_CTRL, 2, 32'h00A5_FF0F, "R4");
  endtask

  task automatic testMap();
    regWrite(A_THR, 0, 32'h0000_1234);
    regWrite(A_THR, 1, 32'h8000_0000);
    regCheck(A_THR, 3, 32'h8000_1234, "R11");
    regWrite(A_CALB, 3, 32'h0000_65D4);
    regCheck(A_CALB, 0, 32'h0000_65D4, "R11");
    regWrite(A_PUD, 0, 32'h0064_0000);
    regCheck(A_PUD, 1, 32'h0064_0000, "R11");
    regCheck(A_CALA, 0, 32'h0, "R11");
    regCheck(A_PER, 0, 32'h0, "R11");
  endtask

  task automatic testTemp();
    @(negedge clk);
    dataIn = 32'h0000_1F40;
    dataLoad = 1'b1;
    @(negedge clk);
    dataLoad = 1'b0;
    regCheck(A_TEMP, 0, 32'h0000_1F40, "R6");
    regWrite(A_TEMP, 0, 32'h0);
    regWrite(A_TEMP, 1, 32'hFFFF_0000);
    regWrite(A_TEMP, 2, 32'h0000_1F40);
    regWrite(A_TEMP, 3, 32'hFFFF_FFFF);
    regCheck(A_TEMP, 0, 32'h0000_1F40, "R6");
  endtask

  task automatic testStatus();
    @(negedge clk);
    hwSet = 32'h0000_0200;
    @(negedge clk);
    hwSet = '0;
    regCheck(A_STAT, 0, 32'h0000_0200, "R7");
    @(negedge clk);
    regCheck(A_STAT, 0, 32'h0000_0200, "R7");
    regWrite(A_STAT, 0, 32'h0);
    regWrite(A_STAT, 3, 32'h0000_0200);
    regWrite(A_STAT, 1, 32'h0001_0000);
    regCheck(A_STAT, 0, 32'h0000_0200, "R7");
    regWrite(A_STAT, 2, 32'h0000_0200);
    regCheck(A_STAT, 0, 32'h0, "R7");
  endtask

  task automatic testPriority();
    @(negedge clk);
    hwSet = 32'h0000_2200;
    @(negedge clk);
    hwSet = 32'h0000_2000;
    addr = wordAddr(A_STAT, 2);
    wrData = 32'h0000_2200;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    hwSet = '0;
    regCheck(A_STAT, 0, 32'h0000_2000, "R8");
  endtask

  task automatic testHole();
    regWrite(A_HOLE, 0, 32'hFFFF_FFFF);
    regWrite(A_HOLE, 1, 32'hFFFF_FFFF);
    regCheck(A_HOLE, 0, 32'h0, "R10");
    regCheck(A_CTRL, 0, 32'h00A5_FF0F, "R10");
    regCheck(A_STAT, 0, 32'h0000_2000, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAliases();
    testMap();
    testTemp();
    testStatus();
    testPriority();
    testHole();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule